// File: doc/BRIEF.md
# Classic Bus Block-Transfer Master

This block is a bus master that runs multi-beat transfers on a classic (non-pipelined) Wishbone-style bus. A local command port starts one transaction at a time. Each transaction is a block read, a block write or an atomic read-then-write of a single location. During a block transfer the bus cycle signal stays high from the first beat to the last, so the master keeps its hold on the interconnect. Between beats the master drops the strobe for one clock.

Each read beat returns its data on a local output with a one-clock valid strobe. Write data is taken from a local input, one word per beat; a pop strobe marks the cycle in which that word is consumed. A single-clock done pulse marks the end of every transaction. Address width, data width, beat-count width and byte versus word addressing are parameters.

Top module: `wbc_block_master`

## Requirements
- R1: While `rst_i` is high at a clock edge, and after it, `cyc_o`, `stb_o`, `done_o` and `rd_valid_o` are low, and the controller is idle.
- R2: A start pulse is accepted only when the controller is idle, `cmd_op_i` is 0 (block read), 1 (block write) or 2 (read-modify-write), and for block operations `cmd_beats_i` is not zero. Op code 3 and a zero beat count for a block operation start no bus cycle and give no done pulse.
- R3: Every read beat drives `we_o` low, `sel_o` equal to `cmd_sel_i` and `stb_o` high. The `dat_i` value at the clock edge where `ack_i` is high is returned on `rd_data_o`, with `rd_valid_o` high for exactly the next clock.
- R4: Every write beat drives `we_o` high and `sel_o` equal to `cmd_sel_i`. Its `dat_o` is the `wr_data_i` word present in the cycle where `wr_pop_o` was high. That cycle is the start cycle for the first beat and the wait-state cycle for each later beat.
- R5: The first beat uses `cmd_addr_i`. Each later beat of a block adds DW/8 to the address with byte addressing (the default), or adds 1 when word addressing is selected.
- R6: While `stb_o` is high and `ack_i` is low, `stb_o`, `adr_o`, `dat_o`, `sel_o` and `we_o` hold their values for any number of clocks.
- R7: After each acknowledged beat that is not the last, `stb_o` is low for exactly one clock while `cyc_o` stays high.
- R8: `cyc_o` stays high from the first beat until the final acknowledge. At that edge `stb_o` and `cyc_o` fall together, and `done_o` is high for the following clock only.
- R9: A read-modify-write performs a read beat at `cmd_addr_i` with `cmd_sel_i`, then one wait state, then a write beat at the same address with `we_o` high, `dat_o` equal to `rmw_wdata_i` and `sel_o` equal to `rmw_sel_i`. All of this happens inside one unbroken `cyc_o` period.
- R10: An `ack_i` that arrives while `stb_o` is low is not counted as a beat and does not shorten the transfer.
- R11: A start pulse that arrives while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_start_i | input | 1 | Start pulse for a transaction |
| cmd_op_i | input | 2 | 0 block read, 1 block write, 2 read-modify-write, 3 reserved |
| cmd_addr_i | input | AW | Address of the first beat |
| cmd_beats_i | input | CW | Beat count for block operations |
| cmd_sel_i | input | DW/8 | Byte selects for block beats and for the read beat of a read-modify-write |
| rmw_wdata_i | input | DW | Write-back value for a read-modify-write |
| rmw_sel_i | input | DW/8 | Byte selects for the write-back beat |
| wr_data_i | input | DW | Write data for the next block-write beat |
| wr_pop_o | output | 1 | `wr_data_i` is consumed at the coming edge |
| rd_data_o | output | DW | Data from the most recent read beat |
| rd_valid_o | output | 1 | `rd_data_o` is new in this cycle |
| done_o | output | 1 | One-clock pulse after a transaction ends |
| adr_o | output | AW | Bus address |
| dat_i | input | DW | Bus read data |
| dat_o | output | DW | Bus write data |
| we_o | output | 1 | Bus write enable |
| sel_o | output | DW/8 | Bus byte selects |
| stb_o | output | 1 | Bus strobe |
| cyc_o | output | 1 | Bus cycle |
| ack_i | input | 1 | Bus acknowledge |

## Verification
On every cycle, the assertions check the following:
- the strobe never appears without the cycle signal;
- the bus outputs stay frozen while a strobe waits for its acknowledge;
- there is a one-clock gap with the cycle signal held after each non-final acknowledge;
- the strobe and the cycle signal fall together, followed by a single done pulse;
- the address steps between beats;
- the write enable flips during a read-modify-write.

Only the bench scenarios can show that the right data reaches the right address in the right order. They also show that byte selects merge correctly in the slave's memory, that illegal or overlapping start pulses launch nothing, and that stray acknowledges in the gap leave the beat sequence intact.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

   typedef enum logic [1:0] {
      OP_BLK_RD = 2'd0,
      OP_BLK_WR = 2'd1,
      OP_RMW    = 2'd2,
      OP_RSVD   = 2'd3
   } wbm_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_GAP  = 2'd2
   } wbm_state_e;

endpackage

// File: rtl/wbm_beat_ctr.sv
module wbm_beat_ctr #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          dec_i,
   output logic          last_o
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= load_val_i;
      end else if (dec_i && (remain_q != '0)) begin
         remain_q <= remain_q - ONE;
      end
   end

   assign last_o = (remain_q == ONE);

   // R10: the count only moves on a real decrement
   a_r10_count_moves_on_dec : assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !dec_i) |=> $stable(remain_q));

endmodule

// File: rtl/wbm_addr_gen.sv
module wbm_addr_gen #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter bit WORD_ADDR = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic [AW-1:0] base_i,
   input  logic          adv_i,
   output logic [AW-1:0] addr_o
);

   localparam int BYTES_PER_BEAT = DW / 8;

   logic [AW-1:0] step;
   logic [AW-1:0] addr_q;

   generate
      if (WORD_ADDR) begin : g_word_step
         assign step = AW'(1);
      end else begin : g_byte_step
         assign step = AW'(BYTES_PER_BEAT);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         addr_q <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
      end else if (adv_i) begin
         addr_q <= addr_q + step;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/wbc_block_master.sv
module wbc_block_master #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 8,
   parameter bit WORD_ADDR = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                cmd_start_i,
   input  logic [1:0]          cmd_op_i,
   input  logic [AW-1:0]       cmd_addr_i,
   input  logic [CW-1:0]       cmd_beats_i,
   input  logic [(DW/8)-1:0]   cmd_sel_i,
   input  logic [DW-1:0]       rmw_wdata_i,
   input  logic [(DW/8)-1:0]   rmw_sel_i,
   input  logic [DW-1:0]       wr_data_i,
   output logic                wr_pop_o,
   output logic [DW-1:0]       rd_data_o,
   output logic                rd_valid_o,
   output logic                done_o,
   output logic [AW-1:0]       adr_o,
   input  logic [DW-1:0]       dat_i,
   output logic [DW-1:0]       dat_o,
   output logic                we_o,
   output logic [(DW/8)-1:0]   sel_o,
   output logic                stb_o,
   output logic                cyc_o,
   input  logic                ack_i
);
   import wbm_pkg::*;

   localparam int SW   = DW / 8;
   localparam int STEP = WORD_ADDR ? 1 : SW;

   generate
      if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
         $error("wbc_block_master: DW must be a whole number of bytes");
      end
      if (CW < 2) begin : g_bad_cw
         $error("wbc_block_master: CW must be at least 2");
      end
      if (AW < 2) begin : g_bad_aw
         $error("wbc_block_master: AW must be at least 2");
      end
   endgenerate

   wbm_state_e     state_q;
   wbm_op_e        op_q;
   wbm_op_e        cmd_op;
   logic           we_q, stb_q, cyc_q, done_q, rdv_q;
   logic [SW-1:0]  sel_q, rmw_sel_q;
   logic [DW-1:0]  dat_q, rmw_dat_q, rdd_q;
   logic           op_legal, accept, beat_ack, beat_last;
   logic [CW-1:0]  beat_load;

   assign cmd_op   = wbm_op_e'(cmd_op_i);
   assign op_legal = (cmd_op == OP_RMW) ||
                     (((cmd_op == OP_BLK_RD) || (cmd_op == OP_BLK_WR)) && (cmd_beats_i != '0));
   assign accept    = (state_q == ST_IDLE) && cmd_start_i && op_legal;
   assign beat_ack  = (state_q == ST_BEAT) && ack_i;
   assign beat_load = (cmd_op == OP_RMW) ? CW'(2) : cmd_beats_i;

   assign wr_pop_o = (accept && (cmd_op == OP_BLK_WR)) ||
                     ((state_q == ST_GAP) && (op_q == OP_BLK_WR));

   wbm_beat_ctr #(.CW(CW)) u_beats (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (accept),
      .load_val_i (beat_load),
      .dec_i      (beat_ack),
      .last_o     (beat_last)
   );

   wbm_addr_gen #(.AW(AW), .DW(DW), .WORD_ADDR(WORD_ADDR)) u_addr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (accept),
      .base_i (cmd_addr_i),
      .adv_i  ((state_q == ST_GAP) && (op_q != OP_RMW)),
      .addr_o (adr_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_BLK_RD;
         we_q      <= 1'b0;
         stb_q     <= 1'b0;
         cyc_q     <= 1'b0;
         done_q    <= 1'b0;
         rdv_q     <= 1'b0;
         sel_q     <= '0;
         rmw_sel_q <= '0;
         dat_q     <= '0;
         rmw_dat_q <= '0;
         rdd_q     <= '0;
      end else begin
         done_q <= 1'b0;
         rdv_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_BEAT;
                  op_q      <= cmd_op;
                  cyc_q     <= 1'b1;
                  stb_q     <= 1'b1;
                  we_q      <= (cmd_op == OP_BLK_WR);
                  sel_q     <= cmd_sel_i;
                  dat_q     <= (cmd_op == OP_BLK_WR) ? wr_data_i : '0;
                  rmw_dat_q <= rmw_wdata_i;
                  rmw_sel_q <= rmw_sel_i;
               end
            end
            ST_BEAT: begin
               if (ack_i) begin
                  stb_q <= 1'b0;
                  if (!we_q) begin
                     rdd_q <= dat_i;
                     rdv_q <= 1'b1;
                  end
                  if (beat_last) begin
                     cyc_q   <= 1'b0;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               stb_q   <= 1'b1;
               state_q <= ST_BEAT;
               if (op_q == OP_RMW) begin
                  we_q  <= 1'b1;
                  dat_q <= rmw_dat_q;
                  sel_q <= rmw_sel_q;
               end else if (op_q == OP_BLK_WR) begin
                  dat_q <= wr_data_i;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dat_o      = dat_q;
   assign we_o       = we_q;
   assign sel_o      = sel_q;
   assign stb_o      = stb_q;
   assign cyc_o      = cyc_q;
   assign done_o     = done_q;
   assign rd_valid_o = rdv_q;
   assign rd_data_o  = rdd_q;

   // R1: outputs quiet in the cycle after reset
   a_r1_reset_quiet : assert property (@(posedge clk_i)
      $past(rst_i) |-> (!cyc_o && !stb_o && !done_o && !rd_valid_o));

   // R8: no strobe outside a bus cycle
   a_r8_stb_in_cyc : assert property (@(posedge clk_i) disable iff (rst_i)
      stb_o |-> cyc_o);

   // R6: slave wait states freeze the bus outputs
   a_r6_hold_on_wait : assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_o && !ack_i) |=> (stb_o && $stable(adr_o) && $stable(dat_o) &&
                             $stable(sel_o) && $stable(we_o)));

   // R7: one-clock master wait state after a non-final acknowledge
   a_r7_gap_after_ack : assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_o && ack_i && !beat_last) |=> (cyc_o && !stb_o));

   // R7: the gap lasts a single clock
   a_r7_gap_one_clock : assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_o && !stb_o) |=> stb_o);

   // R8: strobe and cycle fall together, then a single done pulse
   a_r8_end_of_block : assert property (@(posedge clk_i) disable iff (rst_i)
      (stb_o && ack_i && beat_last) |=> (!cyc_o && !stb_o && done_o));

   a_r8_done_single : assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   // R5: block beats step the address
   a_r5_addr_step : assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_o && !stb_o && (op_q != OP_RMW)) |=> (adr_o == $past(adr_o) + AW'(STEP)));

   // R9: write-back beat of a read-modify-write keeps the address
   a_r9_rmw_write : assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_o && !stb_o && (op_q == OP_RMW)) |=> (we_o && stb_o && $stable(adr_o)));

   // R10: an acknowledge during the gap does not end the cycle
   a_r10_gap_ack_ignored : assert property (@(posedge clk_i) disable iff (rst_i)
      (cyc_o && !stb_o && ack_i) |=> cyc_o);

endmodule

// File: tb/wbc_block_master_tb.sv
module wbc_block_master_tb;

   localparam int  CLK_PERIOD = 10;
   localparam int  AW = 32;
   localparam int  DW = 32;
   localparam int  CW = 8;
   localparam int  SW = DW / 8;

   typedef struct {
      logic [AW-1:0] adr;
      logic          we;
      logic [SW-1:0] sel;
      logic [DW-1:0] dat;
   } beat_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic          cmd_start = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [CW-1:0] cmd_beats = '0;
   logic [SW-1:0] cmd_sel = '0;
   logic [DW-1:0] rmw_wdata = '0;
   logic [SW-1:0] rmw_sel = '0;
   logic [DW-1:0] wr_data;
   logic          wr_pop;
   logic [DW-1:0] rd_data;
   logic          rd_valid, done;
   logic [AW-1:0] adr;
   logic [DW-1:0] dat_i = '0;
   logic [DW-1:0] dat_o;
   logic          we, stb, cyc;
   logic [SW-1:0] sel;
   logic          ack = 1'b0;

   int checks = 0;
   int failures = 0;

   logic [DW-1:0] mem [64];
   logic [DW-1:0] wq [16];
   int            wr_idx = 0;
   beat_t         exp_q [$];
   logic [DW-1:0] exp_rd [$];
   int  slave_wait = 0;
   bit  spur_en = 1'b0;
   int  done_cnt = 0, gap_cnt = 0, cyc_cnt = 0, beat_cnt = 0;
   logic cyc_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign wr_data = wq[wr_idx & 15];

   wbc_block_master #(.AW(AW), .DW(DW), .CW(CW), .WORD_ADDR(1'b0)) u_dut (
      .clk_i(clk), .rst_i(rst), .cmd_start_i(cmd_start), .cmd_op_i(cmd_op),
      .cmd_addr_i(cmd_addr), .cmd_beats_i(cmd_beats), .cmd_sel_i(cmd_sel),
      .rmw_wdata_i(rmw_wdata), .rmw_sel_i(rmw_sel), .wr_data_i(wr_data),
      .wr_pop_o(wr_pop), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
      .done_o(done), .adr_o(adr), .dat_i(dat_i), .dat_o(dat_o), .we_o(we),
      .sel_o(sel), .stb_o(stb), .cyc_o(cyc), .ack_i(ack));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [SW-1:0] s);
      logic [DW-1:0] r = old;
      for (int b = 0; b < SW; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   // write-data feeder: sample the pop strobe mid-cycle, advance after the edge
   always @(negedge clk) begin
      bit pop_s;
      #2;
      pop_s = wr_pop;
      @(posedge clk);
      #1;
      if (pop_s) wr_idx++;
   end

   // slave model and beat scoreboard
   logic [AW-1:0] hold_adr;
   logic [DW-1:0] hold_dat;
   int wcnt = 0;
   always @(negedge clk) begin
      if (rst) begin
         ack = 1'b0;
         wcnt = 0;
      end else if (cyc && stb && !ack) begin
         if (wcnt == 0) begin
            hold_adr = adr;
            hold_dat = dat_o;
         end else begin
            check(adr == hold_adr && dat_o == hold_dat, "R6 hold during slave wait", adr, hold_adr);
         end
         if (wcnt >= slave_wait) begin
            beat_t e;
            ack = 1'b1;
            wcnt = 0;
            beat_cnt++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected beat", adr, 0);
            end else begin
               e = exp_q.pop_front();
               check(adr == e.adr, "R5 beat address", adr, e.adr);
               check(we == e.we, "R3/R4 beat direction", we, e.we);
               check(sel == e.sel, "R3/R4 beat select", sel, e.sel);
               if (e.we) check(dat_o == e.dat, "R4 beat write data", dat_o, e.dat);
            end
            if (we) mem[adr[7:2]] = merge(mem[adr[7:2]], dat_o, sel);
            else    dat_i = mem[adr[7:2]];
         end else begin
            wcnt++;
         end
      end else begin
         ack = spur_en && cyc && !stb;
      end
   end

   // output monitor: read data, gaps, done
   always @(negedge clk) begin
      if (!rst) begin
         if (rd_valid) begin
            if (exp_rd.size() == 0) check(1'b0, "R3 unexpected read data", rd_data, 0);
            else begin
               logic [DW-1:0] x;
               x = exp_rd.pop_front();
               check(rd_data == x, "R3 read data", rd_data, x);
            end
         end
         if (cyc && !stb) gap_cnt++;
         if (cyc) cyc_cnt++;
         if (done) begin
            done_cnt++;
            check(!cyc && cyc_prev, "R8 done after cycle end", cyc, 0);
         end
      end
      cyc_prev = cyc;
   end

   task automatic pulse_start(input logic [1:0] op, input logic [AW-1:0] a, input int n,
                              input logic [SW-1:0] s, input logic [DW-1:0] rd, input logic [SW-1:0] rs);
      @(negedge clk);
      cmd_op = op; cmd_addr = a; cmd_beats = CW'(n); cmd_sel = s;
      rmw_wdata = rd; rmw_sel = rs; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   // driver: pushes expected beats and read data, then runs the transaction
   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input int n,
                         input logic [SW-1:0] s, input logic [DW-1:0] rd, input logic [SW-1:0] rs,
                         input bit busy_poke);
      int d0, b0, beats;
      beat_t e;
      logic [DW-1:0] shadow [64];
      for (int i = 0; i < 64; i++) shadow[i] = mem[i];
      beats = (op == 2'd2) ? 2 : n;
      if (op == 2'd2) begin
         e.adr = a; e.we = 1'b0; e.sel = s; e.dat = '0; exp_q.push_back(e);
         exp_rd.push_back(shadow[a[7:2]]);
         e.adr = a; e.we = 1'b1; e.sel = rs; e.dat = rd; exp_q.push_back(e);
      end else begin
         for (int i = 0; i < n; i++) begin
            e.adr = a + AW'(4*i); e.we = (op == 2'd1); e.sel = s;
            e.dat = (op == 2'd1) ? wq[(wr_idx + i) & 15] : '0;
            exp_q.push_back(e);
            if (op == 2'd0) exp_rd.push_back(shadow[e.adr[7:2]]);
         end
      end
      gap_cnt = 0; d0 = done_cnt; b0 = beat_cnt;
      pulse_start(op, a, n, s, rd, rs);
      if (busy_poke) pulse_start(2'd1, a + 32'h80, 3, 4'hF, 32'h0, 4'h0);
      while (done_cnt == d0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(done_cnt == d0 + 1, "R8 one done pulse", done_cnt - d0, 1);
      check(gap_cnt == beats - 1, "R7 gap cycles", gap_cnt, beats - 1);
      check(beat_cnt - b0 == beats, "R10 beat count", beat_cnt - b0, beats);
      check(exp_q.size() == 0 && exp_rd.size() == 0, "R11 all expected beats seen",
            exp_q.size(), 0);
   endtask

   task automatic expect_ignored(input logic [1:0] op, input int n, input string req);
      int d0, c0;
      d0 = done_cnt; c0 = cyc_cnt;
      pulse_start(op, 32'h20, n, 4'hF, 32'h0, 4'h0);
      repeat (8) @(negedge clk);
      check(cyc_cnt == c0 && done_cnt == d0, req, cyc_cnt - c0, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 ^ (32'h01030507 * i);
      for (int i = 0; i < 16; i++) wq[i] = 32'h5EED0000 + 32'h00011111 * i;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!cyc && !stb && !done && !rd_valid, "R1 reset state", {cyc, stb, done, rd_valid}, 0);
      rst = 1'b0;
      @(negedge clk);
      check(!cyc && !stb, "R1 idle after reset", {cyc, stb}, 0);

      // R3 R5 R7 R8: block read, no slave waits
      slave_wait = 0;
      run_op(2'd0, 32'h10, 4, 4'hF, '0, '0, 1'b0);
      // R6: block read with slave wait states
      slave_wait = 2;
      run_op(2'd0, 32'h40, 3, 4'hF, '0, '0, 1'b0);
      // R4: block write with partial selects
      slave_wait = 1;
      run_op(2'd1, 32'h60, 4, 4'b0110, '0, '0, 1'b0);
      // R4: read the written block back
      slave_wait = 0;
      run_op(2'd0, 32'h60, 4, 4'hF, '0, '0, 1'b0);
      // R9: read-modify-write
      slave_wait = 1;
      run_op(2'd2, 32'h84, 0, 4'hF, 32'hC0DEF00D, 4'b1100, 1'b0);
      check(mem[33] == merge(32'hA5000000 ^ (32'h01030507 * 33), 32'hC0DEF00D, 4'b1100),
            "R9 merged write-back", mem[33], 0);
      // R10: stray acknowledges during the gap
      slave_wait = 1; spur_en = 1'b1;
      run_op(2'd0, 32'h00, 3, 4'hF, '0, '0, 1'b0);
      spur_en = 1'b0;
      // R2: illegal commands
      expect_ignored(2'd0, 0, "R2 zero-beat read ignored");
      expect_ignored(2'd1, 0, "R2 zero-beat write ignored");
      expect_ignored(2'd3, 4, "R2 reserved op ignored");
      // R11: start while busy
      slave_wait = 1;
      run_op(2'd0, 32'h20, 5, 4'hF, '0, '0, 1'b1);
      // R5: single-beat block
      slave_wait = 0;
      run_op(2'd1, 32'hFC, 1, 4'hF, '0, '0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule